// File: doc/BRIEF.md
# Digital PLL Mode Controller

This block decides which of four operating modes a single digital PLL is in and, from that mode, produces the frequency control word for the PLL's numerically controlled oscillator. In free-run the word is a fixed nominal value that depends only on the local oscillator. In locked mode it follows the loop filter's frequency estimate. In holdover it repeats a stored average of past locked-mode words. In DCO mode the loop is open and an external servo writes the word directly.

The controller watches the reference-valid flag from reference selection, the loop's lock indication, the loop filter estimate, a DCO request and the host-written DCO word. A history averager runs only after lock has been held without a break for a set qualification time. When the reference is lost, the mode falls back to holdover if a history exists and to free-run if it does not. The frequency word carries 48 fractional bits, so the finest DCO step can be represented.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mode` is 0 (free-run), `freq_word` is `NOMINAL` and `lock_out` is 0. Mode codes: 0 free-run, 1 locked, 2 holdover, 3 DCO.
- R2: In free-run, `freq_word` equals the `NOMINAL` parameter and no input changes it.
- R3: From free-run or holdover, a cycle with `ref_valid` high and `dco_req` low makes `mode` 1 on the next cycle.
- R4: In locked mode, `freq_word` equals the `lf_freq` sampled at the previous clock edge.
- R5: In locked mode, a cycle with `ref_valid` low and `dco_req` low moves to holdover (2) if a history has been captured, and otherwise to free-run (0).
- R6: In holdover, `freq_word` equals the stored history value.
- R7: The history is updated on a cycle where the mode is locked, `lf_locked` and `ref_valid` are both high, and the previous `QUAL_CYCLES` cycles also satisfied those conditions without a break. The first update loads `lf_freq` directly. Each later update adds (`lf_freq` − history) shifted arithmetically right by `AVG_SHIFT`.
- R8: `dco_req` high on any cycle gives `mode` 3 on the next cycle, whatever the other inputs are. In DCO mode, `freq_word` equals the `dco_word` sampled one edge earlier.
- R9: Leaving DCO (`dco_req` low) always goes to free-run for at least one cycle, even while `ref_valid` is high.
- R10: `lock_out` is high exactly on the cycle after an edge at which the next mode is locked and `lf_locked` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Selected reference qualified |
| lf_locked | input | 1 | Loop reports phase lock |
| lf_freq | input | FW | Loop filter frequency estimate |
| dco_req | input | 1 | Request open-loop DCO mode |
| dco_word | input | FW | Host/servo frequency word |
| freq_word | output | FW | Active oscillator control word |
| mode | output | 2 | Current operating mode |
| lock_out | output | 1 | Locked indication |

## Verification
Mode, frequency word and lock output are all registered together, so each of them reflects the inputs present at the clock edge that precedes it: a stimulus driven before edge n can be seen after edge n. The bench drives inputs on the falling edge. It advances its own reference model at the rising edge from those same inputs and compares all three outputs at the next falling edge. History updates count `QUAL_CYCLES` qualifying edges before the first sample. The directed holdover check therefore holds lock for longer than that, gives one differing estimate, and drops the reference on the edge after it.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [1:0] {
    M_FREERUN  = 2'd0,
    M_LOCKED   = 2'd1,
    M_HOLDOVER = 2'd2,
    M_DCO      = 2'd3
  } pll_mode_e;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ref_valid,
  input  logic      dco_req,
  input  logic      hist_valid,
  output pll_mode_e mode_q,
  output pll_mode_e mode_d
);
  always_comb begin
    mode_d = mode_q;
    if (dco_req) mode_d = M_DCO;
    else begin
      unique case (mode_q)
        M_FREERUN:  if (ref_valid) mode_d = M_LOCKED;
        M_LOCKED:   if (!ref_valid) mode_d = hist_valid ? M_HOLDOVER : M_FREERUN;
        M_HOLDOVER: if (ref_valid) mode_d = M_LOCKED;
        M_DCO:      mode_d = M_FREERUN;
        default:    mode_d = M_FREERUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_FREERUN;
    else     mode_q <= mode_d;
  end

  p_dco_override_r8: assert property (@(posedge clk) disable iff (rst)
    dco_req |=> (mode_q == M_DCO));
  p_dco_exit_r9: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_DCO) && !dco_req) |=> (mode_q == M_FREERUN));
  p_holdover_hist_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_HOLDOVER) |-> hist_valid);
endmodule

// File: rtl/dpll_holdover_avg.sv
module dpll_holdover_avg
  import dpll_mode_pkg::*;
#(
  parameter int FW          = 64,
  parameter int QUAL_CYCLES = 16,
  parameter int AVG_SHIFT   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  pll_mode_e     mode_q,
  input  logic          lf_locked,
  input  logic          ref_valid,
  input  logic [FW-1:0] lf_freq,
  output logic [FW-1:0] hist,
  output logic          hist_valid
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

  logic [QW-1:0]        qcnt;
  logic                 active, qualified;
  logic signed [FW:0]   diff;
  logic signed [FW:0]   step;

  assign active    = (mode_q == M_LOCKED) && lf_locked && ref_valid;
  assign qualified = (qcnt == QMAX);
  assign diff      = $signed({1'b0, lf_freq}) - $signed({1'b0, hist});
  assign step      = diff >>> AVG_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt       <= '0;
      hist       <= '0;
      hist_valid <= 1'b0;
    end else begin
      if (!active)        qcnt <= '0;
      else if (!qualified) qcnt <= qcnt + 1'b1;
      if (active && qualified) begin
        hist_valid <= 1'b1;
        if (!hist_valid) hist <= lf_freq;
        else             hist <= hist + step[FW-1:0];
      end
    end
  end

  p_hist_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !(active && qualified) |=> $stable(hist));
  p_qual_bound_r7: assert property (@(posedge clk) disable iff (rst)
    qcnt <= QMAX);
endmodule

// File: rtl/dpll_word_sel.sv
module dpll_word_sel
  import dpll_mode_pkg::*;
#(
  parameter int            FW      = 64,
  parameter logic [FW-1:0] NOMINAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  pll_mode_e     mode_d,
  input  logic          lf_locked,
  input  logic [FW-1:0] lf_freq,
  input  logic [FW-1:0] dco_word,
  input  logic [FW-1:0] hist,
  output logic [FW-1:0] freq_word,
  output logic          lock_out
);
  logic [FW-1:0] word_d;

  always_comb begin
    unique case (mode_d)
      M_LOCKED:   word_d = lf_freq;
      M_HOLDOVER: word_d = hist;
      M_DCO:      word_d = dco_word;
      default:    word_d = NOMINAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_word <= NOMINAL;
      lock_out  <= 1'b0;
    end else begin
      freq_word <= word_d;
      lock_out  <= (mode_d == M_LOCKED) && lf_locked;
    end
  end
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int            FW          = 64,
  parameter int            FRAC_BITS   = 48,
  parameter logic [FW-1:0] NOMINAL     = FW'(1) << FRAC_BITS,
  parameter int            QUAL_CYCLES = 16,
  parameter int            AVG_SHIFT   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_valid,
  input  logic          lf_locked,
  input  logic [FW-1:0] lf_freq,
  input  logic          dco_req,
  input  logic [FW-1:0] dco_word,
  output logic [FW-1:0] freq_word,
  output logic [1:0]    mode,
  output logic          lock_out
);
  pll_mode_e     mode_q, mode_d;
  logic [FW-1:0] hist;
  logic          hist_valid;

  dpll_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .dco_req(dco_req),
    .hist_valid(hist_valid), .mode_q(mode_q), .mode_d(mode_d)
  );

  dpll_holdover_avg #(.FW(FW), .QUAL_CYCLES(QUAL_CYCLES), .AVG_SHIFT(AVG_SHIFT)) u_avg (
    .clk(clk), .rst(rst), .mode_q(mode_q), .lf_locked(lf_locked),
    .ref_valid(ref_valid), .lf_freq(lf_freq), .hist(hist), .hist_valid(hist_valid)
  );

  dpll_word_sel #(.FW(FW), .NOMINAL(NOMINAL)) u_sel (
    .clk(clk), .rst(rst), .mode_d(mode_d), .lf_locked(lf_locked),
    .lf_freq(lf_freq), .dco_word(dco_word), .hist(hist),
    .freq_word(freq_word), .lock_out(lock_out)
  );

  assign mode = mode_q;

  p_lock_mode_r10: assert property (@(posedge clk) disable iff (rst)
    lock_out |-> (mode == 2'd1));
  p_freerun_word_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> (freq_word == NOMINAL));
  p_dco_word_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |-> (freq_word == $past(dco_word)));
  p_holdover_word_r6: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd2) && $past(mode == 2'd2)) |-> $stable(freq_word));
endmodule

// File: tb/sim_dpll_mode_ctrl.sv
module sim_dpll_mode_ctrl;
  localparam int FW = 64;
  localparam logic [FW-1:0] NOM = 64'h0001_0000_0000_0000;
  localparam int QUAL = 16;
  localparam int SH = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic ref_valid = 0, lf_locked = 0, dco_req = 0;
  logic [FW-1:0] lf_freq = NOM, dco_word = '0;
  logic [FW-1:0] freq_word;
  logic [1:0] mode;
  logic lock_out;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] m_mode;
  logic [FW-1:0] m_word, m_hist;
  logic m_lock, m_hv;
  int m_q;

  always #10 clk = ~clk;

  dpll_mode_ctrl #(.FW(FW), .NOMINAL(NOM), .QUAL_CYCLES(QUAL), .AVG_SHIFT(SH)) u0 (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .lf_locked(lf_locked),
    .lf_freq(lf_freq), .dco_req(dco_req), .dco_word(dco_word),
    .freq_word(freq_word), .mode(mode), .lock_out(lock_out));

  function automatic logic [FW-1:0] avg_next(logic [FW-1:0] h, logic [FW-1:0] x);
    logic signed [FW:0] d;
    d = $signed({1'b0, x}) - $signed({1'b0, h});
    d = d >>> SH;
    return h + d[FW-1:0];
  endfunction

  function automatic logic [1:0] next_mode(logic [1:0] m, logic rv, logic dr, logic hv);
    if (dr) return 2'd3;
    case (m)
      2'd0: return rv ? 2'd1 : 2'd0;
      2'd1: return rv ? 2'd1 : (hv ? 2'd2 : 2'd0);
      2'd2: return rv ? 2'd1 : 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 0; m_word = NOM; m_lock = 0; m_hist = '0; m_hv = 0; m_q = 0;
  endtask

  task automatic model_edge();
    logic [1:0] nm;
    logic act;
    nm = next_mode(m_mode, ref_valid, dco_req, m_hv);
    case (nm)
      2'd1: m_word = lf_freq;
      2'd2: m_word = m_hist;
      2'd3: m_word = dco_word;
      default: m_word = NOM;
    endcase
    m_lock = (nm == 2'd1) && lf_locked;
    act = (m_mode == 2'd1) && lf_locked && ref_valid;
    if (act && m_q == QUAL) begin
      m_hist = m_hv ? avg_next(m_hist, lf_freq) : lf_freq;
      m_hv = 1;
    end
    m_q = act ? ((m_q < QUAL) ? m_q + 1 : QUAL) : 0;
    m_mode = nm;
  endtask

  task automatic check(string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    case (m_mode)
      2'd0: t = "R2 free-run word";
      2'd1: t = "R4 locked word";
      2'd2: t = "R6 holdover word";
      default: t = "R8 dco word";
    endcase
    check("mode (R3/R5/R8/R9)", FW'(mode), FW'(m_mode));
    check(t, freq_word, m_word);
    check("R10 lock_out", FW'(lock_out), FW'(m_lock));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin : stim
    logic [FW-1:0] a, b;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    dco_req = 1; ref_valid = 1; dco_word = 64'hDEAD;  // ignored in reset
    @(negedge clk);
    check("R1 reset mode", FW'(mode), 0);
    check("R1 reset word", freq_word, NOM);
    check("R1 reset lock", FW'(lock_out), 0);
    dco_req = 0; ref_valid = 0;
    rst = 0;
    step();
    check("R1 first cycle mode", FW'(mode), 0);
    lf_freq = NOM + 64'h5555;
    repeat (3) step();
    check("R2 word ignores lf_freq", freq_word, NOM);

    // lock without history, then lose ref -> free-run
    ref_valid = 1; lf_locked = 1; lf_freq = NOM + 64'h10;
    step();
    check("R3 enter locked", FW'(mode), 1);
    check("R4 locked word", freq_word, NOM + 64'h10);
    check("R10 lock high", FW'(lock_out), 1);
    ref_valid = 0;
    step();
    check("R5 no history -> free-run", FW'(mode), 0);

    // qualified lock, one differing sample, then holdover
    a = NOM + 64'h800; b = NOM + 64'h1800;
    ref_valid = 1; lf_freq = a;
    repeat (QUAL + 6) step();
    lf_freq = b;
    step();
    ref_valid = 0; lf_freq = a;
    step();
    check("R5 history -> holdover", FW'(mode), 2);
    check("R7 averaged history", freq_word, a + 64'h200);
    check("R6 holdover word", freq_word, m_word);
    check("R10 lock low in holdover", FW'(lock_out), 0);
    ref_valid = 1;
    step();
    check("R3 holdover back to locked", FW'(mode), 1);

    // DCO override and exit
    dco_req = 1; dco_word = 64'h0001_0000_0000_0ABC;
    step();
    check("R8 dco entry", FW'(mode), 3);
    check("R8 dco word", freq_word, 64'h0001_0000_0000_0ABC);
    dco_req = 0;
    step();
    check("R9 dco exit to free-run with ref valid", FW'(mode), 0);
    check("R9 word nominal", freq_word, NOM);
    step();
    check("R3 relock after dco", FW'(mode), 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      ref_valid = ($urandom_range(0, 19) != 0);
      lf_locked = ($urandom_range(0, 9) != 0);
      dco_req   = ($urandom_range(0, 39) == 0) ? ~dco_req : dco_req;
      lf_freq   = NOM + FW'($urandom_range(0, 65535)) - FW'(32768);
      dco_word  = {32'h0000_0001, $urandom()};
      step();
    end
    rst = 1;
    @(posedge clk); model_reset();
    @(negedge clk);
    check("R1 reset again mode", FW'(mode), 0);
    check("R1 reset again word", freq_word, NOM);
    finish_run();
  end
endmodule